// File: doc/BRIEF.md
# Scanline Layer Compositor with Shadow and Highlight

This block merges three pixel-aligned 8-bit index streams (a sprite layer and two background planes, called plane A and plane B) into a single stream of 9-bit RGB pixels, one pixel per clock. For every pixel it picks a winning layer from the priority bits and transparency of the three bytes. Where all three layers are transparent, a programmable background entry is used instead. The winning 6-bit address is looked up in a 64-entry colour RAM that holds 3 bits per channel. An optional shading mode then darkens the pixel (shadow) or brightens it (highlight).

A small line state machine gates the stream. Each line opens with `line_start`, and the block then accepts either 320 or 256 pixels, chosen by `wide_mode`. Any further pixels are dropped until the next line opens. The machine has three states:
- `LN_IDLE` is the state after reset. `line_start` moves it to `LN_ACTIVE` (transition *open*).
- `LN_ACTIVE` stays put while pixels arrive. It moves to `LN_DONE` when the last pixel of the line is accepted (transition *fill*). A new `line_start` re-enters `LN_ACTIVE` with the count cleared (transition *restart*).
- `LN_DONE` moves to `LN_ACTIVE` on `line_start` (transition *reopen*).

The colour RAM is written through a simple write port at any time. Line buffering, tile fetch and video timing are outside this block.

Top module: `layer_compositor`

## Requirements
- R1: A layer byte is bit 6 priority, bits 5:4 palette, bits 3:0 colour, with bit 7 ignored. A colour of 0 makes the whole byte transparent, including its priority bit.
- R2: Among opaque layers, any layer with its priority bit set beats any layer without it. Within the same priority class, the order is sprite, then plane A, then plane B.
- R3: When no layer draws, colour-RAM entry `bg_index` is output.
- R4: The winning layer addresses colour-RAM entry {palette, colour}. The entry's 9 bits appear unchanged on `out_rgb` as R in bits 8:6, G in bits 5:3 and B in bits 2:0, unless shading applies.
- R5: A pixel presented with `in_valid` in cycle t appears with `out_valid` high in cycle t+2. After reset, `out_valid` and `out_rgb` are 0.
- R6: With `sh_enable` high, the pixel is shadowed when no drawn layer has its priority bit set. It shows at normal level otherwise. Shadowing shifts each 3-bit channel right by one.
- R7: With `sh_enable` high, a sprite byte whose low six bits are 0x3F or 0x3E never draws, and its priority bit is ignored. 0x3F forces shadow. 0x3E raises the level one step: shadow becomes normal and normal becomes highlight.
- R8: Highlight shifts each channel right by one and then adds 4, so every channel lands in 4..7.
- R9: With `sh_enable` low, no shading is applied, and sprite bytes 0x3F and 0x3E draw as ordinary colours.
- R10: A colour-RAM write is seen by any pixel looked up in a later cycle. A lookup in the same cycle as the write returns the old entry.
- R11: `wide_mode` is sampled only at `line_start`. It selects 320 pixels when high and 256 when low. Pixels past that count produce no output until the next `line_start`.
- R12: Pixels presented before the first `line_start` after reset produce no output. A `line_start` in mid-line restarts the count, and the pixel presented with it counts as the first pixel of the new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Opens a new line; may coincide with its first pixel |
| wide_mode | input | 1 | 1: 320-pixel line, 0: 256-pixel line (sampled at `line_start`) |
| in_valid | input | 1 | Layer bytes are valid this cycle |
| plane_a | input | 8 | Plane A pixel byte |
| plane_b | input | 8 | Plane B pixel byte |
| sprite | input | 8 | Sprite pixel byte |
| sh_enable | input | 1 | Enables shadow/highlight processing |
| bg_index | input | 6 | Colour-RAM entry used where no layer draws |
| cram_we | input | 1 | Colour-RAM write enable |
| cram_waddr | input | 6 | Colour-RAM write address |
| cram_wdata | input | 9 | Colour-RAM write data, RGB 3:3:3 |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 9 | Output pixel, R 8:6, G 5:3, B 2:0 |

## Verification
A colour-RAM write and the second-stage lookup of a pixel can land in the same clock cycle. The bench provokes this by presenting a pixel that selects entry 0x12 and then writing a new value to 0x12 in the following cycle, which is the cycle in which that pixel reads the RAM. The pixel must come out with the old colour, and the next pixel with the same address must come out with the new colour. A second overlap occurs when `line_start` arrives together with a pixel while the line is still active. That pixel must be counted as the first pixel of the fresh line, which is judged by where the line cut-off falls afterwards.

// File: rtl/lc_pkg.sv
package lc_pkg;

    // Output intensity level applied after the colour lookup
    typedef enum logic [1:0] {
        LVL_NORMAL = 2'd0,
        LVL_SHADOW = 2'd1,
        LVL_HIGH   = 2'd2
    } level_t;

    // Line gating states
    typedef enum logic [1:0] {
        LN_IDLE   = 2'd0,
        LN_ACTIVE = 2'd1,
        LN_DONE   = 2'd2
    } line_state_t;

endpackage

// File: rtl/lc_line_fsm.sv
module lc_line_fsm
    import lc_pkg::*;
#(
    parameter int WIDE_PIX   = 320,
    parameter int NARROW_PIX = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_start,
    input  logic        wide_mode,
    input  logic        in_valid,
    output logic        pix_accept,
    output line_state_t line_state
);

    localparam int CNT_W = $clog2(WIDE_PIX + 1);
    localparam logic [CNT_W-1:0] WIDE_L   = CNT_W'(WIDE_PIX);
    localparam logic [CNT_W-1:0] NARROW_L = CNT_W'(NARROW_PIX);
    localparam logic [CNT_W-1:0] ONE_L    = CNT_W'(1);

    line_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim_q, lim_d;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + ONE_L;

    // Next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lim_d   = lim_q;
        if (line_start) begin
            // open / restart / reopen
            lim_d   = wide_mode ? WIDE_L : NARROW_L;
            cnt_d   = {{(CNT_W-1){1'b0}}, in_valid};
            state_d = (in_valid && (lim_d == ONE_L)) ? LN_DONE : LN_ACTIVE;
        end else begin
            unique case (state_q)
                LN_IDLE:   state_d = LN_IDLE;
                LN_ACTIVE: begin
                    if (in_valid) begin
                        cnt_d = cnt_inc;
                        if (cnt_inc == lim_q) begin
                            state_d = LN_DONE;   // fill
                        end
                    end
                end
                LN_DONE:   state_d = LN_DONE;
                default:   state_d = LN_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Count and limit registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= NARROW_L;
        end else begin
            cnt_q <= cnt_d;
            lim_q <= lim_d;
        end
    end

    // Outputs
    always_comb begin
        pix_accept = in_valid && (line_start || (state_q == LN_ACTIVE));
        line_state = state_q;
    end

endmodule

// File: rtl/lc_layer_select.sv
module lc_layer_select
    import lc_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int PAL_W = 2
) (
    input  logic [IDX_W+PAL_W+1:0] plane_a,
    input  logic [IDX_W+PAL_W+1:0] plane_b,
    input  logic [IDX_W+PAL_W+1:0] sprite,
    input  logic                   sh_enable,
    input  logic [IDX_W+PAL_W-1:0] bg_index,
    output logic [IDX_W+PAL_W-1:0] sel_addr,
    output level_t                 sel_level
);

    localparam int AW      = IDX_W + PAL_W;
    localparam int LAYER_W = AW + 2;
    localparam int PRI_BIT = AW;
    localparam int NLAYER  = 3;   // index order is the tie-break order
    localparam logic [AW-1:0] OP_SHADOW = {AW{1'b1}};
    localparam logic [AW-1:0] OP_HIGH   = {{(AW-1){1'b1}}, 1'b0};

    logic [LAYER_W-1:0] raw   [NLAYER];
    logic [LAYER_W-1:0] clean [NLAYER];
    logic [NLAYER-1:0]  opaque;
    logic [NLAYER-1:0]  drawn;
    logic [NLAYER-1:0]  pri;
    logic               spr_op_shadow, spr_op_high;
    logic               unused_top;

    assign raw[0] = sprite;
    assign raw[1] = plane_a;
    assign raw[2] = plane_b;

    // Transparency cleanup per layer
    generate
        for (genvar g = 0; g < NLAYER; g++) begin : g_layer
            assign opaque[g] = |raw[g][IDX_W-1:0];
            assign clean[g]  = opaque[g] ? raw[g] : '0;
            assign pri[g]    = clean[g][PRI_BIT] && drawn[g];
        end
    endgenerate

    assign unused_top = ^{clean[0][LAYER_W-1], clean[1][LAYER_W-1], clean[2][LAYER_W-1]};

    assign spr_op_shadow = sh_enable && opaque[0] && (clean[0][AW-1:0] == OP_SHADOW);
    assign spr_op_high   = sh_enable && opaque[0] && (clean[0][AW-1:0] == OP_HIGH);

    assign drawn[0] = opaque[0] && !spr_op_shadow && !spr_op_high;
    assign drawn[1] = opaque[1];
    assign drawn[2] = opaque[2];

    // Winner: priority pass first, then plain pass, then background
    always_comb begin
        logic found;
        found    = 1'b0;
        sel_addr = bg_index;
        for (int i = 0; i < NLAYER; i++) begin
            if (!found && pri[i]) begin
                found    = 1'b1;
                sel_addr = clean[i][AW-1:0];
            end
        end
        for (int i = 0; i < NLAYER; i++) begin
            if (!found && drawn[i]) begin
                found    = 1'b1;
                sel_addr = clean[i][AW-1:0];
            end
        end
    end

    // Intensity level
    always_comb begin
        level_t base;
        base = (|pri) ? LVL_NORMAL : LVL_SHADOW;
        if (!sh_enable) begin
            sel_level = LVL_NORMAL;
        end else if (spr_op_shadow) begin
            sel_level = LVL_SHADOW;
        end else if (spr_op_high) begin
            sel_level = (base == LVL_SHADOW) ? LVL_NORMAL : LVL_HIGH;
        end else begin
            sel_level = base;
        end
    end

endmodule

// File: rtl/lc_color_ram.sv
module lc_color_ram #(
    parameter int AW = 6,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read sees the array as it stood before this cycle's write lands
    assign rdata = mem[raddr];

endmodule

// File: rtl/lc_intensity.sv
module lc_intensity
    import lc_pkg::*;
#(
    parameter int CH_W = 3,
    parameter int NCH  = 3
) (
    input  logic [CH_W*NCH-1:0] rgb_in,
    input  level_t              level,
    output logic [CH_W*NCH-1:0] rgb_out
);

    localparam logic [CH_W-1:0] HALF_SCALE = {1'b1, {(CH_W-1){1'b0}}};

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic [CH_W-1:0] ch, halved;
            assign ch     = rgb_in[c*CH_W +: CH_W];
            assign halved = ch >> 1;
            always_comb begin
                unique case (level)
                    LVL_SHADOW: rgb_out[c*CH_W +: CH_W] = halved;
                    LVL_HIGH:   rgb_out[c*CH_W +: CH_W] = halved + HALF_SCALE;
                    default:    rgb_out[c*CH_W +: CH_W] = ch;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
    import lc_pkg::*;
#(
    parameter int IDX_W      = 4,
    parameter int PAL_W      = 2,
    parameter int CH_W       = 3,
    parameter int WIDE_PIX   = 320,
    parameter int NARROW_PIX = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          line_start,
    input  logic                          wide_mode,
    input  logic                          in_valid,
    input  logic [IDX_W+PAL_W+1:0]        plane_a,
    input  logic [IDX_W+PAL_W+1:0]        plane_b,
    input  logic [IDX_W+PAL_W+1:0]        sprite,
    input  logic                          sh_enable,
    input  logic [IDX_W+PAL_W-1:0]        bg_index,
    input  logic                          cram_we,
    input  logic [IDX_W+PAL_W-1:0]        cram_waddr,
    input  logic [3*CH_W-1:0]             cram_wdata,
    output logic                          out_valid,
    output logic [3*CH_W-1:0]             out_rgb
);

    localparam int AW  = IDX_W + PAL_W;
    localparam int NCH = 3;
    localparam int DW  = NCH * CH_W;

    logic          pix_accept;
    line_state_t   line_state;
    logic [AW-1:0] sel_addr;
    level_t        sel_level;

    logic          v_s1;
    logic [AW-1:0] addr_s1;
    level_t        lvl_s1;

    logic [DW-1:0] cram_rdata;
    logic [DW-1:0] shaded;

    lc_line_fsm #(
        .WIDE_PIX   (WIDE_PIX),
        .NARROW_PIX (NARROW_PIX)
    ) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .wide_mode  (wide_mode),
        .in_valid   (in_valid),
        .pix_accept (pix_accept),
        .line_state (line_state)
    );

    lc_layer_select #(
        .IDX_W (IDX_W),
        .PAL_W (PAL_W)
    ) u_sel (
        .plane_a   (plane_a),
        .plane_b   (plane_b),
        .sprite    (sprite),
        .sh_enable (sh_enable),
        .bg_index  (bg_index),
        .sel_addr  (sel_addr),
        .sel_level (sel_level)
    );

    // Stage 1: resolved address and level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_s1    <= 1'b0;
            addr_s1 <= '0;
            lvl_s1  <= LVL_NORMAL;
        end else begin
            v_s1    <= pix_accept;
            addr_s1 <= sel_addr;
            lvl_s1  <= sel_level;
        end
    end

    lc_color_ram #(
        .AW (AW),
        .DW (DW)
    ) u_cram (
        .clk   (clk),
        .we    (cram_we),
        .waddr (cram_waddr),
        .wdata (cram_wdata),
        .raddr (addr_s1),
        .rdata (cram_rdata)
    );

    lc_intensity #(
        .CH_W (CH_W),
        .NCH  (NCH)
    ) u_int (
        .rgb_in  (cram_rdata),
        .level   (lvl_s1),
        .rgb_out (shaded)
    );

    // Stage 2: output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= v_s1;
            out_rgb   <= v_s1 ? shaded : '0;
        end
    end

endmodule

// File: rtl/lc_checker.sv
module lc_checker
    import lc_pkg::*;
#(
    parameter int CH_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                line_start,
    input logic                sh_enable,
    input logic                acc,
    input line_state_t         line_state,
    input level_t              lvl_s1,
    input logic                out_valid,
    input logic [3*CH_W-1:0]   out_rgb
);

    logic [2:0] msbs;
    generate
        for (genvar c = 0; c < 3; c++) begin : g_msb
            assign msbs[c] = out_rgb[c*CH_W + CH_W - 1];
        end
    endgenerate

    // R5: output valid only follows an input valid two cycles earlier
    p_valid_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R5: an accepted pixel always emerges two cycles later
    p_accept_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> ##2 out_valid);

    // R11: a pixel refused by the line gate produces no output
    p_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !acc) |-> ##2 !out_valid);

    // R11: nothing is accepted after the line is full
    p_done_closed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == LN_DONE && !line_start) |-> !acc);

    // R12: nothing is accepted before the first line opens
    p_idle_closed_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == LN_IDLE && !line_start) |-> !acc);

    // R9: shading disabled means normal level
    p_sh_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_enable |=> (lvl_s1 == LVL_NORMAL));

    // R8: highlighted pixels sit in the upper half of every channel
    p_high_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(lvl_s1) == LVL_HIGH) |-> (msbs == 3'b111));

    // R6: shadowed pixels sit in the lower half of every channel
    p_shadow_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(lvl_s1) == LVL_SHADOW) |-> (msbs == 3'b000));

endmodule

bind layer_compositor lc_checker #(.CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .line_start (line_start),
    .sh_enable  (sh_enable),
    .acc        (pix_accept),
    .line_state (line_state),
    .lvl_s1     (lvl_s1),
    .out_valid  (out_valid),
    .out_rgb    (out_rgb)
);

// File: tb/layer_compositor_tb.sv
`timescale 1ns/1ps
module layer_compositor_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       line_start, wide_mode, in_valid, sh_enable;
    logic [7:0] plane_a, plane_b, sprite;
    logic [5:0] bg_index, cram_waddr;
    logic       cram_we;
    logic [8:0] cram_wdata;
    logic       out_valid;
    logic [8:0] out_rgb;

    int checks = 0;
    int fails  = 0;
    logic [8:0] model [64];

    always #10 clk = ~clk;

    layer_compositor u_dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .wide_mode(wide_mode),
        .in_valid(in_valid), .plane_a(plane_a), .plane_b(plane_b), .sprite(sprite),
        .sh_enable(sh_enable), .bg_index(bg_index), .cram_we(cram_we),
        .cram_waddr(cram_waddr), .cram_wdata(cram_wdata),
        .out_valid(out_valid), .out_rgb(out_rgb)
    );

    // Vector: a[38:31] b[30:23] s[22:15] sh[14] bg[13:8] addr[7:2] lvl[1:0]
    // lvl code: 0 normal, 1 shadow, 2 highlight
    localparam int NVEC = 18;
    localparam logic [38:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 8'h00, 1'b0, 6'h05, 6'h05, 2'd0},  // R3 background
        {8'h12, 8'h00, 8'h00, 1'b0, 6'h05, 6'h12, 2'd0},  // R4 lookup
        {8'h12, 8'h23, 8'h31, 1'b0, 6'h05, 6'h31, 2'd0},  // R2 sprite first
        {8'h12, 8'h63, 8'h31, 1'b0, 6'h05, 6'h23, 2'd0},  // R2 priority B wins
        {8'h52, 8'h63, 8'h31, 1'b0, 6'h05, 6'h12, 2'd0},  // R2 A over B
        {8'h52, 8'h63, 8'h71, 1'b0, 6'h05, 6'h31, 2'd0},  // R2 sprite over A
        {8'hF0, 8'h24, 8'h00, 1'b0, 6'h05, 6'h24, 2'd0},  // R1 transparent pri
        {8'h00, 8'h00, 8'h70, 1'b0, 6'h3A, 6'h3A, 2'd0},  // R1 R3
        {8'h12, 8'h00, 8'h00, 1'b1, 6'h05, 6'h12, 2'd1},  // R6 shadow
        {8'h52, 8'h00, 8'h00, 1'b1, 6'h05, 6'h12, 2'd0},  // R6 priority normal
        {8'h12, 8'h00, 8'h3F, 1'b1, 6'h05, 6'h12, 2'd1},  // R7 op shadow
        {8'h52, 8'h00, 8'h3F, 1'b1, 6'h05, 6'h12, 2'd1},  // R7 op shadow
        {8'h52, 8'h00, 8'h3E, 1'b1, 6'h05, 6'h12, 2'd2},  // R8 highlight
        {8'h12, 8'h00, 8'h3E, 1'b1, 6'h05, 6'h12, 2'd0},  // R7 lift shadow
        {8'h12, 8'h00, 8'h3F, 1'b0, 6'h05, 6'h3F, 2'd0},  // R9 plain colour
        {8'h00, 8'h00, 8'h00, 1'b1, 6'h05, 6'h05, 2'd1},  // R6 shadowed bg
        {8'h12, 8'h00, 8'h7E, 1'b1, 6'h05, 6'h12, 2'd0},  // R7 op pri ignored
        {8'h12, 8'h00, 8'h45, 1'b1, 6'h05, 6'h05, 2'd0}   // R6 sprite pri
    };

    function automatic string vec_tag(int i);
        case (i)
            0:          return "R3";
            1:          return "R4";
            2, 3, 4, 5: return "R2";
            6, 7:       return "R1";
            12:         return "R8";
            14:         return "R9";
            10, 11, 13, 16: return "R7";
            default:    return "R6";
        endcase
    endfunction

    function automatic logic [8:0] init_val(int e);
        return 9'((e * 83 + 17) % 512);
    endfunction

    function automatic logic [8:0] shade(logic [8:0] c, logic [1:0] lvl);
        logic [8:0] r;
        for (int k = 0; k < 3; k++) begin
            logic [2:0] ch;
            ch = c[k*3 +: 3];
            if (lvl == 2'd1)      r[k*3 +: 3] = ch >> 1;
            else if (lvl == 2'd2) r[k*3 +: 3] = (ch >> 1) + 3'd4;
            else                  r[k*3 +: 3] = ch;
        end
        return r;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pixel(input logic [7:0] a, input logic [7:0] b, input logic [7:0] s,
                         input logic sh, input logic [5:0] bg, input logic ls,
                         output logic v_early, output logic v, output logic [8:0] rgb);
        @(negedge clk);
        plane_a = a; plane_b = b; sprite = s; sh_enable = sh; bg_index = bg;
        line_start = ls; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; line_start = 1'b0;
        v_early = out_valid;
        @(negedge clk);
        v = out_valid;
        rgb = out_rgb;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic ve, v;
        logic [8:0] rgb;
        rst_n = 1'b0; line_start = 1'b0; wide_mode = 1'b1; in_valid = 1'b0;
        sh_enable = 1'b0; plane_a = '0; plane_b = '0; sprite = '0; bg_index = '0;
        cram_we = 1'b0; cram_waddr = '0; cram_wdata = '0;
        repeat (3) @(negedge clk);
        check("R5 reset valid", int'(out_valid), 0);
        check("R5 reset rgb", int'(out_rgb), 0);
        rst_n = 1'b1;

        // R12: before any line opens
        pixel(8'h12, 8'h00, 8'h00, 1'b0, 6'h05, 1'b0, ve, v, rgb);
        check("R12 pre-line pixel dropped", int'(v), 0);

        // Load colour RAM
        for (int e = 0; e < 64; e++) begin
            @(negedge clk);
            cram_we = 1'b1; cram_waddr = 6'(e); cram_wdata = init_val(e);
            model[e] = init_val(e);
        end
        @(negedge clk);
        cram_we = 1'b0;

        // Table walk, all within one wide line
        for (int i = 0; i < NVEC; i++) begin
            logic [38:0] w;
            w = VEC[i];
            pixel(w[38:31], w[30:23], w[22:15], w[14], w[13:8], i == 0, ve, v, rgb);
            if (i == 0) check("R5 not valid after one cycle", int'(ve), 0);
            check({vec_tag(i), " valid"}, int'(v), 1);
            check({vec_tag(i), " rgb"}, int'(rgb), int'(shade(model[w[7:2]], w[1:0])));
        end

        // R10: write lands in the cycle the pixel reads the RAM
        @(negedge clk);
        plane_a = 8'h12; plane_b = 8'h00; sprite = 8'h00; sh_enable = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        cram_we = 1'b1; cram_waddr = 6'h12; cram_wdata = ~model[6'h12];
        @(negedge clk);
        cram_we = 1'b0;
        check("R10 same-cycle old data", int'(out_rgb), int'(model[6'h12]));
        model[6'h12] = ~model[6'h12];
        pixel(8'h12, 8'h00, 8'h00, 1'b0, 6'h05, 1'b0, ve, v, rgb);
        check("R10 later read new data", int'(rgb), int'(model[6'h12]));

        // R11: narrow line, width flag flipped mid-line has no effect
        wide_mode = 1'b0;
        for (int k = 1; k <= 257; k++) begin
            if (k == 10) wide_mode = 1'b1;
            pixel(8'h12, 8'h00, 8'h00, 1'b0, 6'h05, k == 1, ve, v, rgb);
            if (k == 256) check("R11 narrow last pixel", int'(v), 1);
            if (k == 257) check("R11 narrow overflow dropped", int'(v), 0);
        end

        // R11: wide line opened from the done state
        wide_mode = 1'b1;
        for (int k = 1; k <= 321; k++) begin
            pixel(8'h12, 8'h00, 8'h00, 1'b0, 6'h05, k == 1, ve, v, rgb);
            if (k == 320) check("R11 wide last pixel", int'(v), 1);
            if (k == 321) check("R11 wide overflow dropped", int'(v), 0);
        end

        // R12: restart in mid-line
        wide_mode = 1'b0;
        for (int k = 1; k <= 200; k++) begin
            pixel(8'h12, 8'h00, 8'h00, 1'b0, 6'h05, k == 1, ve, v, rgb);
        end
        for (int k = 1; k <= 257; k++) begin
            pixel(8'h12, 8'h00, 8'h00, 1'b0, 6'h05, k == 1, ve, v, rgb);
            if (k == 256) check("R12 restarted line last pixel", int'(v), 1);
            if (k == 257) check("R12 restarted line overflow", int'(v), 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule